// File: doc/BRIEF.md
# Built-In Self-Test Pattern Generator and Response Compressor

This block is the datapath of a built-in self-test. A four-stage shift-right linear feedback shift register produces a pseudorandom test vector on every enabled clock. The vector drives a circuit under test that sits outside the block. The circuit's four-bit response comes back on `resp_i`, and a signature register folds it into a compact four-bit signature. After a run of a known length, logic elsewhere compares that signature with a golden value.

The signature register uses the same feedback structure as the generator. In parallel mode all four response bits are XORed into the four stages. In serial mode only response bit 0 is folded in, at the feedback point, and the register then acts as a single-input compressor. A synchronous seed input starts every run from a known point. The run-enable input makes the number of vectors exactly controllable.

Top module: `bist_lfsr_misr`

## Requirements
- R1: A clock edge with `seed_i` high sets `vec_o` to 4'b1000 and `sig_o` to 4'b0000, whatever `run_i` is.
- R2: On an edge with `run_i` high and `seed_i` low, the generator shifts toward bit 0: new `vec_o[2:0]` is old `vec_o[3:1]`, and new `vec_o[3]` is the old `fbit_o`.
- R3: `fbit_o` always equals `vec_o[3]` XOR `vec_o[0]`.
- R4: Starting from the seed, successive enabled edges give the vectors 8,C,E,F,7,B,5,A,D,6,3,9,4,2,1 (hex). After 15 steps the vector is 4'b1000 again.
- R5: After seeding, `vec_o` never becomes 4'b0000.
- R6: While `run_i` is low and `seed_i` is low, both `vec_o` and `sig_o` hold their values.
- R7: With `mode_i` = 0 (parallel), an enabled edge loads `sig_o` with {p3^s3^s0, p2^s3, p1^s2, p0^s1}, where p is `resp_i` and s is the old signature.
- R8: With `mode_i` = 1 (serial), an enabled edge loads `sig_o` with {p0^s3^s0, s3, s2, s1}. `resp_i[3:1]` has no effect on the signature.
- R9: Two response streams of equal length that differ in a single bit of one vector give different final signatures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| seed_i | input | 1 | Synchronous reset and seed load, active high |
| run_i | input | 1 | Advance generator and compressor on this edge |
| mode_i | input | 1 | Compressor mode: 0 parallel, 1 serial (bit 0 only) |
| resp_i | input | 4 | Response from the circuit under test |
| vec_o | output | 4 | Current test vector (generator state) |
| fbit_o | output | 1 | Generator feedback bit, also the serial pseudorandom stream |
| sig_o | output | 4 | Current signature |

## Verification
The assertions check on every cycle the seeding result, the hold while disabled and the non-zero generator state. They also check the return to the seed after every fifteenth step, using a step counter, and the plain shift of the lower signature stages in serial mode. Only the bench scenarios can show that the exact 15-vector order is correct and that the parallel and serial folding of particular response streams gives the expected signatures. The same applies to the upper response bits being ignored in serial mode and to a single flipped response bit changing the final signature.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic {
    CMP_PARALLEL = 1'b0,
    CMP_SERIAL   = 1'b1
  } cmp_mode_e;

  // Feedback tap shared by generator and compressor: both end stages.
  function automatic logic end_tap(input logic msb, input logic lsb);
    return msb ^ lsb;
  endfunction

endpackage

// File: rtl/bist_prbs_gen.sv
module bist_prbs_gen
  import bist_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         seed_i,
  input  logic         run_i,
  output logic [W-1:0] vec_o,
  output logic         fbit_o
);

  localparam logic [W-1:0] SEED   = {1'b1, {(W-1){1'b0}}};
  localparam int           PERIOD = (1 << W) - 1;
  localparam int           CW     = $clog2(PERIOD + 1);

  logic [W-1:0] st;
  logic         fb;
  logic         step_en;

  assign fb      = end_tap(st[W-1], st[0]);
  assign step_en = run_i && !seed_i;

  always_ff @(posedge clk) begin
    if (seed_i)       st <= SEED;
    else if (run_i)   st <= {fb, st[W-1:1]};
  end

  assign vec_o  = st;
  assign fbit_o = fb;

  // Step counter kept only for the period assertion.
  logic [CW-1:0] wrap_cnt;
  always_ff @(posedge clk) begin
    if (seed_i)
      wrap_cnt <= '0;
    else if (step_en)
      wrap_cnt <= (wrap_cnt == CW'(PERIOD - 1)) ? '0 : wrap_cnt + 1'b1;
  end

  a_r1_seed_vec: assert property (@(posedge clk)
    seed_i |=> (vec_o == SEED));

  a_r5_nonzero: assert property (@(posedge clk) disable iff (seed_i)
    vec_o != '0);

  a_r6_vec_hold: assert property (@(posedge clk) disable iff (seed_i)
    !run_i |=> $stable(vec_o));

  a_r4_period: assert property (@(posedge clk) disable iff (seed_i)
    (step_en && wrap_cnt == CW'(PERIOD - 1)) |=> (vec_o == SEED));

  a_r2_shift_low: assert property (@(posedge clk) disable iff (seed_i)
    step_en |=> (vec_o[W-2:0] == $past(vec_o[W-1:1])));

endmodule

// File: rtl/bist_sig_comp.sv
module bist_sig_comp
  import bist_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         seed_i,
  input  logic         run_i,
  input  cmp_mode_e    mode_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] sig_o
);

  logic [W-1:0] sig_q;
  logic [W-1:0] sig_nxt;
  logic [W-1:0] fold_bit;
  logic [W-1:0] shift_in;
  logic         step_en;

  assign step_en = run_i && !seed_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == W - 1) begin : g_head
      assign shift_in[i] = end_tap(sig_q[W-1], sig_q[0]);
      assign fold_bit[i] = (mode_i == CMP_SERIAL) ? resp_i[0] : resp_i[i];
    end else begin : g_body
      assign shift_in[i] = sig_q[i+1];
      assign fold_bit[i] = (mode_i == CMP_SERIAL) ? 1'b0 : resp_i[i];
    end
    assign sig_nxt[i] = shift_in[i] ^ fold_bit[i];
  end

  always_ff @(posedge clk) begin
    if (seed_i)      sig_q <= '0;
    else if (run_i)  sig_q <= sig_nxt;
  end

  assign sig_o = sig_q;

  a_r1_sig_clear: assert property (@(posedge clk)
    seed_i |=> (sig_o == '0));

  a_r6_sig_hold: assert property (@(posedge clk) disable iff (seed_i)
    !run_i |=> $stable(sig_o));

  a_r8_serial_shift: assert property (@(posedge clk) disable iff (seed_i)
    (step_en && mode_i == CMP_SERIAL) |=> (sig_o[W-2:0] == $past(sig_o[W-1:1])));

endmodule

// File: rtl/bist_lfsr_misr.sv
module bist_lfsr_misr
  import bist_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         seed_i,
  input  logic         run_i,
  input  logic         mode_i,
  input  logic [W-1:0] resp_i,
  output logic [W-1:0] vec_o,
  output logic         fbit_o,
  output logic [W-1:0] sig_o
);

  cmp_mode_e cmp_mode;
  assign cmp_mode = cmp_mode_e'(mode_i);

  bist_prbs_gen #(.W(W)) u_gen (
    .clk    (clk),
    .seed_i (seed_i),
    .run_i  (run_i),
    .vec_o  (vec_o),
    .fbit_o (fbit_o)
  );

  bist_sig_comp #(.W(W)) u_comp (
    .clk    (clk),
    .seed_i (seed_i),
    .run_i  (run_i),
    .mode_i (cmp_mode),
    .resp_i (resp_i),
    .sig_o  (sig_o)
  );

  always_comb begin
    a_r3_fbit: assert (fbit_o == (vec_o[W-1] ^ vec_o[0]));
  end

endmodule

// File: tb/test_bist_lfsr_misr.sv
module test_bist_lfsr_misr;

  logic       clk = 1'b0;
  logic       seed_i = 1'b1;
  logic       run_i = 1'b0;
  logic       mode_i = 1'b0;
  logic [3:0] resp_i = 4'h0;
  logic [3:0] vec_o;
  logic       fbit_o;
  logic [3:0] sig_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  bist_lfsr_misr i_bist_lfsr_misr (
    .clk    (clk),
    .seed_i (seed_i),
    .run_i  (run_i),
    .mode_i (mode_i),
    .resp_i (resp_i),
    .vec_o  (vec_o),
    .fbit_o (fbit_o),
    .sig_o  (sig_o)
  );

  logic [3:0] seq [15] = '{4'h8, 4'hC, 4'hE, 4'hF, 4'h7, 4'hB, 4'h5, 4'hA,
                           4'hD, 4'h6, 4'h3, 4'h9, 4'h4, 4'h2, 4'h1};

  // Reference folding, written bitwise from R7 and R8.
  function automatic logic [3:0] ref_par(input logic [3:0] s, input logic [3:0] p);
    logic [3:0] r;
    r[3] = p[3] ^ s[3] ^ s[0];
    r[2] = p[2] ^ s[3];
    r[1] = p[1] ^ s[2];
    r[0] = p[0] ^ s[1];
    return r;
  endfunction

  function automatic logic [3:0] ref_ser(input logic [3:0] s, input logic p0);
    return {p0 ^ s[3] ^ s[0], s[3:1]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_seed();
    seed_i = 1'b1;
    run_i  = 1'b0;
    tick();
    seed_i = 1'b0;
  endtask

  task automatic t_reset();
    do_seed();
    chk("R1 vec after seed", vec_o, 4'h8);
    chk("R1 sig after seed", sig_o, 4'h0);
    chk("R3 fbit at seed", {3'b0, fbit_o}, 4'h1);
  endtask

  task automatic t_sequence();
    logic [3:0] prev;
    do_seed();
    run_i = 1'b1;
    mode_i = 1'b0;
    resp_i = 4'h0;
    for (int k = 0; k < 15; k++) begin
      chk("R4 sequence", vec_o, seq[k]);
      chk("R3 feedback", {3'b0, fbit_o}, {3'b0, vec_o[3] ^ vec_o[0]});
      if (vec_o == 4'h0) chk("R5 nonzero", vec_o, 4'h1);
      prev = vec_o;
      tick();
      chk("R2 shift", vec_o, {prev[3] ^ prev[0], prev[3], prev[2], prev[1]});
    end
    chk("R4 period back to seed", vec_o, 4'h8);
    run_i = 1'b0;
  endtask

  task automatic t_hold();
    logic [3:0] v0, s0;
    do_seed();
    run_i = 1'b1;
    resp_i = 4'h5;
    mode_i = 1'b0;
    tick(); tick(); tick();
    run_i = 1'b0;
    v0 = vec_o;
    s0 = sig_o;
    resp_i = 4'hF;
    for (int k = 0; k < 4; k++) tick();
    chk("R6 vec holds", vec_o, v0);
    chk("R6 sig holds", sig_o, s0);
  endtask

  task automatic t_seed_priority();
    do_seed();
    run_i = 1'b1;
    resp_i = 4'h3;
    tick(); tick();
    seed_i = 1'b1;
    tick();
    seed_i = 1'b0;
    run_i = 1'b0;
    chk("R1 seed beats run vec", vec_o, 4'h8);
    chk("R1 seed beats run sig", sig_o, 4'h0);
  endtask

  task automatic t_parallel();
    logic [3:0] m;
    do_seed();
    mode_i = 1'b0;
    run_i = 1'b1;
    m = 4'h0;
    for (int k = 0; k < 15; k++) begin
      resp_i = {vec_o[0], vec_o[3:1]} ^ 4'h6;
      m = ref_par(m, resp_i);
      tick();
      chk("R7 parallel fold", sig_o, m);
    end
    run_i = 1'b0;
  endtask

  task automatic run_serial(input logic [3:1] upper, output logic [3:0] fin);
    logic [3:0] m;
    do_seed();
    mode_i = 1'b1;
    run_i = 1'b1;
    m = 4'h0;
    for (int k = 0; k < 12; k++) begin
      resp_i = {upper ^ vec_o[3:1], vec_o[2] ^ vec_o[0]};
      m = ref_ser(m, resp_i[0]);
      tick();
      chk("R8 serial fold", sig_o, m);
    end
    run_i = 1'b0;
    fin = sig_o;
  endtask

  task automatic t_serial_ignore();
    logic [3:0] a, b;
    run_serial(3'b000, a);
    run_serial(3'b101, b);
    chk("R8 upper bits ignored", b, a);
    mode_i = 1'b0;
  endtask

  task automatic run_stream(input int flip_at, output logic [3:0] fin);
    logic [3:0] m;
    do_seed();
    mode_i = 1'b0;
    run_i = 1'b1;
    m = 4'h0;
    for (int k = 0; k < 15; k++) begin
      resp_i = vec_o ^ ((k == flip_at) ? 4'h4 : 4'h0);
      m = ref_par(m, resp_i);
      tick();
    end
    run_i = 1'b0;
    fin = sig_o;
    chk("R9 stream signature", fin, m);
  endtask

  task automatic t_distinct();
    logic [3:0] a, b;
    run_stream(-1, a);
    run_stream(7, b);
    total++;
    if (a === b) begin
      bad++;
      $display("FAIL R9 distinct signatures: actual=%h expected!=%h", b, a);
    end
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    t_reset();
    t_sequence();
    t_hold();
    t_seed_priority();
    t_parallel();
    t_serial_ignore();
    t_distinct();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule